// File: doc/BRIEF.md
# Nonvolatile Data Word Memory Write Controller

This block sequences erase and program operations on a small nonvolatile data store of 512 sixteen-bit words. The store is modelled here as an on-chip register array. A host reaches the block through four register slots: a control register, an address register, a data latch, and a window onto the array word at the current address. Register writes complete in the cycle they are issued. Reads are combinational. The interface never back-pressures the host.

An operation erases or programs either one word or a 16-word row that starts on a row boundary. Once started, it runs for `OP_CYCLES` clock cycles and the host keeps running. The default suits a 2 ms program time; a bench uses a short value. When the operation ends, the block applies the result to the array, clears the start bit and raises a sticky completion flag.

A warm reset that lands during an operation stops it and sets a sticky error bit. The array and the address register are left as they were. A power-on reset clears every control bit.

Top module: `nvm_write_ctrl`

## Requirements
- R1: After power-on reset the control register reads 0 (start bit 0, enable bit 1, error bit 2, done flag bit 3, operation field bits 5:4), the address register reads 0, and `busy` and `irq` are low.
- R2: The address register holds a byte offset into the 512-word store. Bit 0 always reads 0. Word index = offset bits 9:1. A row operation acts on the 16 words whose index shares bits 9:5.
- R3: The start bit is set only by a host write of 1. A host write of 0 does not clear it while an operation runs. Hardware clears it when the operation ends. `busy` equals the start bit.
- R4: A start write is accepted only if the enable bit was already 1 before that write and no operation is running. Otherwise the start bit stays as it was and the array does not change.
- R5: A warm reset during an operation sets the error bit, clears the start bit, and leaves the address register, the enable bit and the array unchanged. The done flag is not set. A warm reset while idle leaves the error bit as it is. A host write of 0 to the error bit clears it.
- R6: When an operation completes, the done flag and `irq` go to 1. A host write of 0 to bit 3 clears them. A host write of 1 never sets them.
- R7: `busy` stays high for exactly `OP_CYCLES` clock cycles for each operation that is not interrupted.
- R8: Operation code 00 (erase word) sets the addressed word to 0xFFFF and leaves every other word unchanged.
- R9: Operation code 01 (erase row) sets all 16 words of the addressed row to 0xFFFF. This includes the last row of the store.
- R10: Operation code 10 (program word) stores the bitwise AND of the old word and the data latch. Operation code 11 (program row) applies that AND to every word of the row.
- R11: Reading register slot 3 while idle returns the array word selected by the address register. Slot 0 is control, slot 1 is address and slot 2 is the data latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset (external or watchdog), synchronous, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register slot: 0 control, 1 address, 2 data latch, 3 array word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected slot |
| busy | output | 1 | An operation is in progress |
| irq | output | 1 | Completion interrupt flag |

## Verification
The assertions check the following on every cycle:
- the start bit holds until completion or a warm reset;
- an operation starts only with the enable bit already set;
- an interrupted operation leaves the error bit set and the address unchanged;
- completion raises the flag;
- the busy window has the exact length.

Only the bench scenarios show the array contents. These include the AND behaviour of programming without an erase, row alignment at the store's last row, that neighbouring words are left untouched, and that rejected or interrupted starts leave the data intact.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_ERASE_WORD = 2'b00,
    OP_ERASE_ROW  = 2'b01,
    OP_PROG_WORD  = 2'b10,
    OP_PROG_ROW   = 2'b11
  } nvm_op_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd2;
  localparam logic [1:0] SEL_ARRAY = 2'd3;

  localparam int CB_GO  = 0;
  localparam int CB_ARM = 1;
  localparam int CB_ERR = 2;
  localparam int CB_IRQ = 3;
  localparam int CB_OP  = 4;
endpackage

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int OP_CYCLES = 80000
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic abort,
  output logic last
);
  localparam int CNT_W = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(OP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt_q <= '0;
    else if (!run || abort)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && !abort && (cnt_q == LIM);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int WORDS     = 512,
  parameter int ROW_WORDS = 16,
  parameter int DATA_W    = 16
) (
  input  logic                      clk,
  input  logic                      commit,
  input  logic                      erase,
  input  logic                      row_mode,
  input  logic [$clog2(WORDS)-1:0]  idx,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [$clog2(WORDS)-1:0]  rd_idx,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int ROW_SH = $clog2(ROW_WORDS);

  logic [DATA_W-1:0] words [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [IDX_W-1:0] IV = IDX_W'(i);
    logic [DATA_W-1:0] q;
    logic hit;
    assign hit = row_mode ? (idx[IDX_W-1:ROW_SH] == IV[IDX_W-1:ROW_SH])
                          : (idx == IV);
    always_ff @(posedge clk) begin
      if (commit && hit) q <= erase ? {DATA_W{1'b1}} : (q & wdata);
    end
    assign words[i] = q;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_pkg::*;
#(
  parameter int WORDS     = 512,
  parameter int ROW_WORDS = 16,
  parameter int DATA_W    = 16,
  parameter int OP_CYCLES = 80000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              busy,
  output logic              irq
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int OFF_W = IDX_W + 1;

  logic              go_q, arm_q, err_q, irq_q;
  nvm_op_e           op_q, cap_op_q;
  logic [OFF_W-1:0]  addr_q;
  logic [DATA_W-1:0] data_q, cap_data_q;
  logic [IDX_W-1:0]  cap_idx_q;
  logic              ctrl_wr, go_req, op_done;
  logic [DATA_W-1:0] arr_rd;

  assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
  assign go_req  = ctrl_wr && reg_wdata[CB_GO] && arm_q && !go_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      go_q       <= 1'b0;
      arm_q      <= 1'b0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      op_q       <= OP_ERASE_WORD;
      cap_op_q   <= OP_ERASE_WORD;
      addr_q     <= '0;
      data_q     <= '0;
      cap_data_q <= '0;
      cap_idx_q  <= '0;
    end else if (warm_rst) begin
      go_q <= 1'b0;
      if (go_q) err_q <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        arm_q <= reg_wdata[CB_ARM];
        err_q <= err_q & reg_wdata[CB_ERR];
        if (!go_q) op_q <= nvm_op_e'(reg_wdata[CB_OP+1:CB_OP]);
      end
      if (go_req) begin
        go_q       <= 1'b1;
        cap_op_q   <= nvm_op_e'(reg_wdata[CB_OP+1:CB_OP]);
        cap_idx_q  <= addr_q[OFF_W-1:1];
        cap_data_q <= data_q;
      end else if (op_done) begin
        go_q <= 1'b0;
      end
      irq_q <= (irq_q & ~(ctrl_wr & ~reg_wdata[CB_IRQ])) | op_done;
      if (reg_we && reg_sel == SEL_ADDR) addr_q <= {reg_wdata[OFF_W-1:1], 1'b0};
      if (reg_we && reg_sel == SEL_DATA) data_q <= reg_wdata;
    end
  end

  nvm_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk   (clk),
    .por_n (por_n),
    .run   (go_q),
    .abort (warm_rst),
    .last  (op_done)
  );

  nvm_cell_array #(.WORDS(WORDS), .ROW_WORDS(ROW_WORDS), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .commit   (op_done),
    .erase    (!cap_op_q[1]),
    .row_mode (cap_op_q[0]),
    .idx      (cap_idx_q),
    .wdata    (cap_data_q),
    .rd_idx   (addr_q[OFF_W-1:1]),
    .rd_data  (arr_rd)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[CB_GO]            = go_q;
        reg_rdata[CB_ARM]           = arm_q;
        reg_rdata[CB_ERR]           = err_q;
        reg_rdata[CB_IRQ]           = irq_q;
        reg_rdata[CB_OP+1:CB_OP]    = op_q;
      end
      SEL_ADDR:  reg_rdata[OFF_W-1:0] = addr_q;
      SEL_DATA:  reg_rdata = data_q;
      default:   reg_rdata = arr_rd;
    endcase
  end

  assign busy = go_q;
  assign irq  = irq_q;
endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk #(
  parameter int OP_CYCLES = 80000,
  parameter int OFF_W     = 10
) (
  input logic             clk,
  input logic             por_n,
  input logic             warm_rst,
  input logic             busy,
  input logic             arm_q,
  input logic             err_q,
  input logic             irq,
  input logic             op_done,
  input logic [OFF_W-1:0] addr_q
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     run_len <= 0;
    else if (!busy) run_len <= 0;
    else            run_len <= run_len + 1;
  end

  p_go_held_r3: assert property (@(posedge clk) disable iff (!por_n)
    busy && !op_done && !warm_rst |=> busy);

  p_start_needs_arm_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(arm_q));

  p_warm_sets_err_r5: assert property (@(posedge clk) disable iff (!por_n)
    busy && warm_rst |=> err_q && !busy);

  p_warm_keeps_addr_r5: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |=> $stable(addr_q));

  p_done_raises_irq_r6: assert property (@(posedge clk) disable iff (!por_n)
    op_done |=> irq);

  p_busy_length_r7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(busy) && !$past(warm_rst) |-> run_len == OP_CYCLES);
endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk #(.OP_CYCLES(OP_CYCLES), .OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .warm_rst (warm_rst),
  .busy     (busy),
  .arm_q    (arm_q),
  .err_q    (err_q),
  .irq      (irq),
  .op_done  (op_done),
  .addr_q   (addr_q)
);

// File: tb/sim_nvm_write_ctrl.sv
module sim_nvm_write_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int OPC        = 12;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] chk;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h0020, 16'h0000, 16'h003E, 16'hFFFF},
    '{2'd2, 16'h0024, 16'h1234, 16'h0024, 16'h1234},
    '{2'd2, 16'h0024, 16'hFF0F, 16'h0024, 16'h1204},
    '{2'd0, 16'h0024, 16'h0000, 16'h0024, 16'hFFFF},
    '{2'd3, 16'h003E, 16'hA5A5, 16'h0020, 16'hA5A5},
    '{2'd0, 16'h0022, 16'h0000, 16'h0022, 16'hFFFF},
    '{2'd2, 16'h0022, 16'h00FF, 16'h0024, 16'hA5A5},
    '{2'd1, 16'h03FE, 16'h0000, 16'h03E0, 16'hFFFF},
    '{2'd2, 16'h03FE, 16'h0001, 16'h03FE, 16'h0001},
    '{2'd2, 16'h03FF, 16'h00FF, 16'h03FE, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_write_ctrl #(.OP_CYCLES(OPC)) u0 (
    .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 4 * OPC) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd(2'd0, v); check("R1 ctrl after por", v, 16'h0000);
    rd(2'd1, v); check("R1 addr after por", v, 16'h0000);
    check("R1 busy/irq after por", {14'd0, busy, irq}, 16'h0000);

    wr(2'd0, 16'h0002);
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VEC[i].addr);
      wr(2'd2, VEC[i].data);
      wr(2'd0, {10'd0, VEC[i].op, 4'b0011});
      wait_idle(n);
      check("R7 busy length", 16'(n), 16'(OPC));
      check("R6 irq after op", {15'd0, irq}, 16'h0001);
      wr(2'd1, VEC[i].chk);
      rd(2'd3, v);
      check("R8 R9 R10 R11 array word", v, VEC[i].exp);
      wr(2'd0, 16'h0002);
      check("R6 irq cleared", {15'd0, irq}, 16'h0000);
    end

    // R2: odd offset has bit 0 dropped
    wr(2'd1, 16'h03FF);
    rd(2'd1, v); check("R2 addr bit0", v, 16'h03FE);

    // R6: writing 1 to the done bit does not set it
    wr(2'd0, 16'h000A);
    check("R6 sw set ignored", {15'd0, irq}, 16'h0000);

    // R4: start with enable clear is ignored
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0031);
    check("R4 no start without enable", {15'd0, busy}, 16'h0000);
    wr(2'd0, 16'h0033);
    check("R4 enable in same write", {15'd0, busy}, 16'h0000);
    repeat (OPC + 2) @(negedge clk);
    rd(2'd3, v); check("R4 array untouched", v, 16'h0001);

    // R3 and R4: start bit cannot be cleared, restart while busy ignored
    wr(2'd0, 16'h0003);
    wr(2'd0, 16'h0032);
    check("R3 write 0 keeps busy", {15'd0, busy}, 16'h0001);
    rd(2'd0, v); check("R3 start bit reads 1", {15'd0, v[0]}, 16'h0001);
    wr(2'd0, 16'h0033);
    wait_idle(n);
    rd(2'd0, v); check("R3 hw clears start", {15'd0, v[0]}, 16'h0000);
    rd(2'd3, v); check("R4 second start ignored", v, 16'hFFFF);
    wr(2'd0, 16'h0002);

    // R5: warm reset mid-operation
    wr(2'd1, 16'h0020);
    wr(2'd0, 16'h0013);
    repeat (3) @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    rd(2'd0, v);
    check("R5 ctrl after warm", v[3:0], 16'h0006);
    check("R5 busy after warm", {15'd0, busy}, 16'h0000);
    rd(2'd1, v); check("R5 addr kept", v, 16'h0020);
    repeat (OPC) @(negedge clk);
    rd(2'd3, v); check("R5 array kept", v, 16'hA5A5);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    rd(2'd0, v); check("R5 idle warm keeps err", {15'd0, v[2]}, 16'h0001);
    wr(2'd0, 16'h0002);
    rd(2'd0, v); check("R5 sw clears err", {15'd0, v[2]}, 16'h0000);

    // R1: power-on reset clears everything again
    wr(2'd0, 16'h0006);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R1 ctrl after second por", v, 16'h0000);
    rd(2'd1, v); check("R1 addr after second por", v, 16'h0000);

    finish_run();
  end
endmodule